// File: doc/BRIEF.md
# Core Module System Control Register File

This block is the control and identification register file of a processor core module. A host reaches it over a plain 32-bit register bus: one request per cycle, a write enable, a byte address whose low two bits are ignored, and read data returned one cycle after a read request. The file holds a fixed identity word and a fixed status word. It also holds two oscillator settings that can only be changed after a 16-bit unlock key is written. A control register drives a status LED, the boot remap select and a board reset request. Two flag banks each have their own set and clear addresses. A memory-configuration word and an init word are plain read/write storage.

The upper half of the address window is a read-only presence-detect byte window that describes the fitted memory. One byte of it, and the size field of the memory-configuration word, follow the `MEM_MB` parameter. A small local interrupt block has a single software-driven source, with separate IRQ and FIQ enable masks and level outputs. The high-frequency counters, the processor word and the voltage words read as zero. Any other unmapped word also reads zero and ignores writes.

Top module: `cm_sysctl_regs`

## Requirements
- R1: Word 0 reads 0x411A3001 and word 4 reads 0x00100000. Words 1, 6, 10, 11, 13, 15 and 32 to 35, and every other word not named in these requirements, read zero. Writes to them change nothing that can be read back.
- R2: A write to word 5 stores data bits [15:0] as the lock value and drops the upper bits. A read of word 5 returns 0x0001A05F while the stored value is 0xA05F, and returns the zero-extended stored value otherwise. The lock value resets to zero.
- R3: Words 2 (oscillator) and 7 (auxiliary oscillator) take a write only while the lock value equals 0xA05F. Any other write to them is ignored. Both values are driven on `osc_cfg_o` and `aux_osc_cfg_o`.
- R4: After reset the oscillator reads 0x01000048, the auxiliary oscillator reads 0x0007FEFF, init (word 9) reads 0x00000112 and control (word 3) reads 0. Memory configuration (word 8) reads 0x00011122 ORed with a size code: 0x10 for MEM_MB ≥ 256, 0x0C for ≥ 128, 0x08 for ≥ 64, 0x04 for ≥ 32, else 0.
- R5: Flags read at word 12. A write to word 12 ORs the data into the flags, and a write to word 13 clears every flag bit that is set in the data.
- R6: The second flag bank reads at word 14. It is set at word 14 and cleared at word 15 with the same rules, and it is independent of the first bank.
- R7: A write to word 3 with data bit 3 set raises `reset_req_o` for exactly one cycle, starting at the clock edge that takes the write. Bit 3 is not stored, so it reads back as zero.
- R8: Control bit 0 drives `led_o` and control bit 2 drives `remap_o` as levels from the stored control value. `remap_o` low means the flash alias sits at address zero.
- R9: For byte offsets 0x100 to 0x17F, word k of that window (k = (offset − 0x100) >> 2) reads presence-detect byte k in bits [7:0]. Byte 0 is 128, byte 1 is 8, byte 3 is 11, byte 9 is 0xA0, and byte 31 is 64/32/16/4/2 for MEM_MB ≥ 256/128/64/32/less. Offsets 0x180 to 0x1FF read zero.
- R10: Word 18 ORs data into the IRQ enable mask and word 19 clears the mask bits set in the data. Word 26 and word 27 do the same for the FIQ enable mask. Words 18 and 26 read the masks, words 17 and 25 read the raw level, and words 16 and 24 read the raw level ANDed with the IRQ or FIQ mask.
- R11: The raw level has one source, at bit 0. A write to word 20 sets it and a write to word 21 clears it, and only when data bit 0 is 1. Other data bits have no effect. A read of word 20 returns the raw bit.
- R12: `irq_o` is the OR of the raw level ANDed with the IRQ mask, and `fiq_o` is the same with the FIQ mask. Both follow the registers combinationally.
- R13: `rvalid_o` is high in the cycle after each read request and low otherwise. `rdata_o` carries the word as it stood before that clock edge.
- R14: Words 8 and 9 store all 32 written bits and read them back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus request, one access per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address; bits [1:0] ignored |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| osc_cfg_o | output | 32 | Oscillator setting |
| aux_osc_cfg_o | output | 32 | Auxiliary oscillator setting |
| led_o | output | 1 | Status LED, control bit 0 |
| remap_o | output | 1 | Boot remap select, control bit 2 |
| reset_req_o | output | 1 | One-cycle board reset request |
| irq_o | output | 1 | Local IRQ level |
| fiq_o | output | 1 | Local FIQ level |

## Verification
The bench builds the block with MEM_MB = 64. This places the size code at 0x08 and sets presence-detect byte 31 to 16. That value differs from the default build's 32, so a size decode that ignores the parameter shows up in both the memory-configuration read and the window read. It also exercises the lock key with junk in the upper data bits, writes to the oscillators before and after unlocking and after relocking, and soft-source writes whose data bit 0 is clear.

// File: rtl/cm_sysctl_pkg.sv
package cm_sysctl_pkg;

  localparam int unsigned DATA_W = 32;

  // word indices (byte offset >> 2)
  localparam int W_ID       = 0;
  localparam int W_OSC      = 2;
  localparam int W_CTRL     = 3;
  localparam int W_STAT     = 4;
  localparam int W_LOCK     = 5;
  localparam int W_AUXOSC   = 7;
  localparam int W_SDRAM    = 8;
  localparam int W_INIT     = 9;
  localparam int W_FLAG_SET = 12;
  localparam int W_FLAG_CLR = 13;
  localparam int W_NVF_SET  = 14;
  localparam int W_NVF_CLR  = 15;
  localparam int W_IRQ_STAT = 16;
  localparam int W_IRQ_RAW  = 17;
  localparam int W_IRQ_ENS  = 18;
  localparam int W_IRQ_ENC  = 19;
  localparam int W_SOFT_SET = 20;
  localparam int W_SOFT_CLR = 21;
  localparam int W_FIQ_STAT = 24;
  localparam int W_FIQ_RAW  = 25;
  localparam int W_FIQ_ENS  = 26;
  localparam int W_FIQ_ENC  = 27;
  localparam int W_SPD_LO   = 64;
  localparam int W_SPD_HI   = 96;

  localparam logic [31:0] ID_VALUE   = 32'h411A_3001;
  localparam logic [31:0] STAT_VALUE = 32'h0010_0000;
  localparam logic [15:0] LOCK_KEY   = 16'hA05F;
  localparam logic [31:0] OSC_RST    = 32'h0100_0048;
  localparam logic [31:0] AUX_RST    = 32'h0007_FEFF;
  localparam logic [31:0] INIT_RST   = 32'h0000_0112;
  localparam logic [31:0] SDRAM_BASE = 32'h0001_1122;

  localparam int CTRL_LED_BIT   = 0;
  localparam int CTRL_REMAP_BIT = 2;
  localparam int CTRL_RST_BIT   = 3;

  function automatic logic [31:0] sdram_size_code(int unsigned mb);
    if (mb >= 256)      return 32'h10;
    else if (mb >= 128) return 32'h0C;
    else if (mb >= 64)  return 32'h08;
    else if (mb >= 32)  return 32'h04;
    else                return 32'h00;
  endfunction

  function automatic logic [7:0] spd_size_byte(int unsigned mb);
    if (mb >= 256)      return 8'd64;
    else if (mb >= 128) return 8'd32;
    else if (mb >= 64)  return 8'd16;
    else if (mb >= 32)  return 8'd4;
    else                return 8'd2;
  endfunction

  function automatic logic [7:0] spd_byte(logic [4:0] idx, int unsigned mb);
    case (idx)
      5'd0:  return 8'd128;
      5'd1:  return 8'd8;
      5'd2:  return 8'd4;
      5'd3:  return 8'd11;
      5'd4:  return 8'd9;
      5'd5:  return 8'd1;
      5'd6:  return 8'd64;
      5'd8:  return 8'd2;
      5'd9:  return 8'hA0;
      5'd10: return 8'hA0;
      5'd13: return 8'd8;
      5'd15: return 8'd1;
      5'd16: return 8'h0E;
      5'd17: return 8'd4;
      5'd18: return 8'h1C;
      5'd19: return 8'd1;
      5'd20: return 8'd2;
      5'd21: return 8'h20;
      5'd22: return 8'hC0;
      5'd27: return 8'h30;
      5'd28: return 8'h28;
      5'd29: return 8'h30;
      5'd30: return 8'h28;
      5'd31: return spd_size_byte(mb);
      default: return 8'd0;
    endcase
  endfunction

endpackage

// File: rtl/cm_sysctl_lock.sv
module cm_sysctl_lock #(
  parameter int unsigned DATA_W = 32,
  parameter logic [15:0] KEY    = 16'hA05F,
  parameter logic [DATA_W-1:0] OSC_INIT = '0,
  parameter logic [DATA_W-1:0] AUX_INIT = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lock_we_i,
  input  logic              osc_we_i,
  input  logic              aux_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              open_o,
  output logic [DATA_W-1:0] lock_rd_o,
  output logic [DATA_W-1:0] osc_o,
  output logic [DATA_W-1:0] aux_o
);
  logic [15:0] lock_q;

  assign open_o = (lock_q == KEY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= '0;
      osc_o  <= OSC_INIT;
      aux_o  <= AUX_INIT;
    end else begin
      if (lock_we_i)           lock_q <= wdata_i[15:0];
      if (osc_we_i && open_o)  osc_o  <= wdata_i;
      if (aux_we_i && open_o)  aux_o  <= wdata_i;
    end
  end

  // open key reads back with bit 16 set
  always_comb begin
    lock_rd_o         = '0;
    lock_rd_o[15:0]   = lock_q;
    lock_rd_o[16]     = open_o;
  end
endmodule

// File: rtl/cm_sysctl_setclr.sv
module cm_sysctl_setclr #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_we_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] val_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       val_o <= '0;
    else if (set_we_i) val_o <= val_o | wdata_i;
    else if (clr_we_i) val_o <= val_o & ~wdata_i;
  end
endmodule

// File: rtl/cm_sysctl_intc.sv
module cm_sysctl_intc #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         irq_ens_i,
  input  logic         irq_enc_i,
  input  logic         fiq_ens_i,
  input  logic         fiq_enc_i,
  input  logic         soft_set_i,
  input  logic         soft_clr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] raw_o,
  output logic [W-1:0] irq_en_o,
  output logic [W-1:0] fiq_en_o,
  output logic         irq_o,
  output logic         fiq_o
);
  logic soft_q;

  cm_sysctl_setclr #(.W(W)) u_irq_en (
    .clk_i, .rst_ni, .set_we_i(irq_ens_i), .clr_we_i(irq_enc_i),
    .wdata_i, .val_o(irq_en_o)
  );

  cm_sysctl_setclr #(.W(W)) u_fiq_en (
    .clk_i, .rst_ni, .set_we_i(fiq_ens_i), .clr_we_i(fiq_enc_i),
    .wdata_i, .val_o(fiq_en_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        soft_q <= 1'b0;
    else if (soft_set_i && wdata_i[0])  soft_q <= 1'b1;
    else if (soft_clr_i && wdata_i[0])  soft_q <= 1'b0;
  end

  always_comb begin
    raw_o    = '0;
    raw_o[0] = soft_q;
  end

  assign irq_o = |(raw_o & irq_en_o);
  assign fiq_o = |(raw_o & fiq_en_o);
endmodule

// File: rtl/cm_sysctl_regs.sv
module cm_sysctl_regs
  import cm_sysctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned MEM_MB = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              rvalid_o,
  output logic [31:0]       osc_cfg_o,
  output logic [31:0]       aux_osc_cfg_o,
  output logic              led_o,
  output logic              remap_o,
  output logic              reset_req_o,
  output logic              irq_o,
  output logic              fiq_o
);
  localparam int unsigned WORD_W = ADDR_W - 2;
  localparam int unsigned NBANK  = 2;
  localparam logic [31:0] SDRAM_RST = SDRAM_BASE | sdram_size_code(MEM_MB);

  logic [WORD_W-1:0] word;
  int                word_i;
  logic              wr_en, rd_en;

  assign word   = addr_i[ADDR_W-1:2];
  assign word_i = int'(word);
  assign wr_en  = req_i & we_i;
  assign rd_en  = req_i & ~we_i;

  logic unused_addr;
  assign unused_addr = ^addr_i[1:0];

  function automatic logic hit(int w);
    return wr_en && (word_i == w);
  endfunction

  // lock and oscillators
  logic        lock_open;
  logic [31:0] lock_rd;

  cm_sysctl_lock #(
    .DATA_W(DATA_W), .KEY(LOCK_KEY), .OSC_INIT(OSC_RST), .AUX_INIT(AUX_RST)
  ) u_lock (
    .clk_i, .rst_ni,
    .lock_we_i(hit(W_LOCK)),
    .osc_we_i (hit(W_OSC)),
    .aux_we_i (hit(W_AUXOSC)),
    .wdata_i,
    .open_o   (lock_open),
    .lock_rd_o(lock_rd),
    .osc_o    (osc_cfg_o),
    .aux_o    (aux_osc_cfg_o)
  );

  // two set/clear flag banks: 0 at words 12/13, 1 at words 14/15
  logic [31:0] flag_val [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    cm_sysctl_setclr #(.W(DATA_W)) u_bank (
      .clk_i, .rst_ni,
      .set_we_i(hit(W_FLAG_SET + 2*b)),
      .clr_we_i(hit(W_FLAG_CLR + 2*b)),
      .wdata_i,
      .val_o   (flag_val[b])
    );
  end

  // local interrupts
  logic [31:0] int_raw, irq_en, fiq_en;

  cm_sysctl_intc #(.W(DATA_W)) u_intc (
    .clk_i, .rst_ni,
    .irq_ens_i (hit(W_IRQ_ENS)),
    .irq_enc_i (hit(W_IRQ_ENC)),
    .fiq_ens_i (hit(W_FIQ_ENS)),
    .fiq_enc_i (hit(W_FIQ_ENC)),
    .soft_set_i(hit(W_SOFT_SET)),
    .soft_clr_i(hit(W_SOFT_CLR)),
    .wdata_i,
    .raw_o     (int_raw),
    .irq_en_o  (irq_en),
    .fiq_en_o  (fiq_en),
    .irq_o,
    .fiq_o
  );

  // plain storage, control, reset pulse
  logic [31:0] ctrl_q, sdram_q, init_q;
  logic        rst_req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= '0;
      sdram_q   <= SDRAM_RST;
      init_q    <= INIT_RST;
      rst_req_q <= 1'b0;
    end else begin
      rst_req_q <= hit(W_CTRL) && wdata_i[CTRL_RST_BIT];
      if (hit(W_CTRL)) begin
        ctrl_q               <= wdata_i;
        ctrl_q[CTRL_RST_BIT] <= 1'b0;
      end
      if (hit(W_SDRAM)) sdram_q <= wdata_i;
      if (hit(W_INIT))  init_q  <= wdata_i;
    end
  end

  assign led_o       = ctrl_q[CTRL_LED_BIT];
  assign remap_o     = ctrl_q[CTRL_REMAP_BIT];
  assign reset_req_o = rst_req_q;

  // read mux
  logic [31:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    if (word_i >= W_SPD_LO && word_i < W_SPD_HI) begin
      rd_mux[7:0] = spd_byte(word[4:0], MEM_MB);
    end else begin
      case (word_i)
        W_ID:       rd_mux = ID_VALUE;
        W_OSC:      rd_mux = osc_cfg_o;
        W_CTRL:     rd_mux = ctrl_q;
        W_STAT:     rd_mux = STAT_VALUE;
        W_LOCK:     rd_mux = lock_rd;
        W_AUXOSC:   rd_mux = aux_osc_cfg_o;
        W_SDRAM:    rd_mux = sdram_q;
        W_INIT:     rd_mux = init_q;
        W_FLAG_SET: rd_mux = flag_val[0];
        W_NVF_SET:  rd_mux = flag_val[1];
        W_IRQ_STAT: rd_mux = int_raw & irq_en;
        W_IRQ_RAW:  rd_mux = int_raw;
        W_IRQ_ENS:  rd_mux = irq_en;
        W_SOFT_SET: rd_mux = int_raw;
        W_FIQ_STAT: rd_mux = int_raw & fiq_en;
        W_FIQ_RAW:  rd_mux = int_raw;
        W_FIQ_ENS:  rd_mux = fiq_en;
        default:    rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd_en;
      if (rd_en) rdata_o <= rd_mux;
    end
  end
endmodule

// File: rtl/cm_sysctl_regs_chk.sv
module cm_sysctl_regs_chk #(
  parameter int unsigned ADDR_W = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       wdata_i,
  input logic              rvalid_o,
  input logic [31:0]       osc_cfg_o,
  input logic [31:0]       aux_osc_cfg_o,
  input logic              reset_req_o,
  input logic              irq_o,
  input logic              fiq_o,
  input logic              lock_open
);
  import cm_sysctl_pkg::*;

  logic rd, wr;
  int   w;
  assign rd = req_i && !we_i;
  assign wr = req_i && we_i;
  assign w  = int'(addr_i[ADDR_W-1:2]);

  AST_RVALID_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd |=> rvalid_o);                                                 // R13
  AST_NO_SPURIOUS_RVALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> !rvalid_o);                                               // R13
  AST_RESET_REQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_req_o |=> !reset_req_o);                                    // R7
  AST_RESET_REQ_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && w == W_CTRL && wdata_i[3]) |=> reset_req_o);               // R7
  AST_OSC_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && w == W_OSC && !lock_open) |=> $stable(osc_cfg_o));         // R3
  AST_AUX_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && w == W_AUXOSC && !lock_open) |=> $stable(aux_osc_cfg_o));  // R3
  AST_IRQ_MASK_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && w == W_IRQ_ENC && wdata_i[0]) |=> !irq_o);                 // R12
  AST_FIQ_MASK_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && w == W_FIQ_ENC && wdata_i[0]) |=> !fiq_o);                 // R12
  AST_SOFT_CLR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && w == W_SOFT_CLR && wdata_i[0]) |=> (!irq_o && !fiq_o));    // R11
endmodule

bind cm_sysctl_regs cm_sysctl_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_i        (req_i),
  .we_i         (we_i),
  .addr_i       (addr_i),
  .wdata_i      (wdata_i),
  .rvalid_o     (rvalid_o),
  .osc_cfg_o    (osc_cfg_o),
  .aux_osc_cfg_o(aux_osc_cfg_o),
  .reset_req_o  (reset_req_o),
  .irq_o        (irq_o),
  .fiq_o        (fiq_o),
  .lock_open    (lock_open)
);

// File: tb/cm_sysctl_regs_tb.sv
module cm_sysctl_regs_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 9;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [8:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, osc_cfg, aux_cfg;
  logic        rvalid, led, remap, rst_req, irq, fiq;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cm_sysctl_regs #(.ADDR_W(ADDR_W), .MEM_MB(64)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid),
    .osc_cfg_o(osc_cfg), .aux_osc_cfg_o(aux_cfg), .led_o(led),
    .remap_o(remap), .reset_req_o(rst_req), .irq_o(irq), .fiq_o(fiq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // monitor: pop expected read data as results appear
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R13: actual unexpected rvalid expected none");
      end else begin
        chk(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
  end

  task automatic wr(int unsigned a, logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = 9'(a); wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(int unsigned a, logic [31:0] e, string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    req = 1'b1; we = 1'b0; addr = 9'(a);
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state (R4, R8, R12, R13)
    chk("R13 rvalid idle", 32'(rvalid), 0);
    chk("R8 led reset", 32'(led), 0);
    chk("R8 remap reset", 32'(remap), 0);
    chk("R7 reset_req idle", 32'(rst_req), 0);
    chk("R12 irq reset", 32'(irq), 0);
    chk("R12 fiq reset", 32'(fiq), 0);
    chk("R4 osc port reset", osc_cfg, 32'h0100_0048);
    chk("R4 aux port reset", aux_cfg, 32'h0007_FEFF);
    rd('h08, 32'h0100_0048, "R4 osc");
    rd('h1C, 32'h0007_FEFF, "R4 aux osc");
    rd('h24, 32'h0000_0112, "R4 init");
    rd('h20, 32'h0001_112A, "R4 sdram size code MEM_MB=64");
    rd('h0C, 32'h0, "R4 ctrl");
    rd('h14, 32'h0, "R2 lock reset");

    // constants and zero words (R1)
    rd('h00, 32'h411A_3001, "R1 id");
    rd('h10, 32'h0010_0000, "R1 status");
    rd('h04, 0, "R1 proc");
    rd('h18, 0, "R1 bus counter");
    rd('h28, 0, "R1 refresh counter");
    rd('h2C, 0, "R1 word 11");
    rd('h80, 0, "R1 voltage 0");
    rd('h8C, 0, "R1 voltage 3");
    wr('h04, 32'hFFFF_FFFF);
    wr('h2C, 32'hFFFF_FFFF);
    wr('h80, 32'hFFFF_FFFF);
    rd('h04, 0, "R1 proc after write");
    rd('h2C, 0, "R1 word 11 after write");
    rd('h80, 0, "R1 voltage after write");

    // lock and oscillators (R2, R3)
    wr('h08, 32'hDEAD_BEEF);
    wr('h1C, 32'hDEAD_BEEF);
    rd('h08, 32'h0100_0048, "R3 osc locked");
    rd('h1C, 32'h0007_FEFF, "R3 aux locked");
    wr('h14, 32'hFFFF_A05F);
    rd('h14, 32'h0001_A05F, "R2 key readback");
    wr('h08, 32'h1234_5678);
    wr('h1C, 32'h00AB_CDEF);
    rd('h08, 32'h1234_5678, "R3 osc unlocked");
    rd('h1C, 32'h00AB_CDEF, "R3 aux unlocked");
    chk("R3 osc port", osc_cfg, 32'h1234_5678);
    chk("R3 aux port", aux_cfg, 32'h00AB_CDEF);
    wr('h14, 32'hABCD_1234);
    rd('h14, 32'h0000_1234, "R2 low half stored");
    wr('h08, 32'h0);
    rd('h08, 32'h1234_5678, "R3 osc relocked");

    // flags (R5, R6)
    wr('h30, 32'h0000_F00F);
    wr('h30, 32'h0000_0100);
    rd('h30, 32'h0000_F10F, "R5 flags set");
    wr('h34, 32'h0000_100F);
    rd('h30, 32'h0000_E100, "R5 flags clear");
    rd('h34, 0, "R1 flag clear word reads zero");
    wr('h38, 32'hA000_0005);
    rd('h38, 32'hA000_0005, "R6 nv flags set");
    wr('h3C, 32'h8000_0001);
    rd('h38, 32'h2000_0004, "R6 nv flags clear");
    rd('h30, 32'h0000_E100, "R6 banks independent");

    // control (R7, R8)
    wr('h0C, 32'h0000_000D);
    chk("R7 reset_req pulse", 32'(rst_req), 1);
    chk("R8 led on", 32'(led), 1);
    chk("R8 remap on", 32'(remap), 1);
    idle();
    chk("R7 reset_req one cycle", 32'(rst_req), 0);
    rd('h0C, 32'h0000_0005, "R7 bit3 not stored");
    wr('h0C, 32'h0000_0001);
    chk("R7 no pulse without bit3", 32'(rst_req), 0);
    chk("R8 remap off", 32'(remap), 0);
    chk("R8 led stays", 32'(led), 1);

    // plain storage (R14)
    wr('h20, 32'hCAFE_F00D);
    wr('h24, 32'h5555_AAAA);
    rd('h20, 32'hCAFE_F00D, "R14 sdram rw");
    rd('h24, 32'h5555_AAAA, "R14 init rw");

    // presence-detect window (R9)
    rd('h100, 32'd128, "R9 spd byte 0");
    rd('h104, 32'd8, "R9 spd byte 1");
    rd('h10C, 32'd11, "R9 spd byte 3");
    rd('h124, 32'hA0, "R9 spd byte 9");
    rd('h11C, 32'h0, "R9 spd byte 7");
    rd('h17C, 32'd16, "R9 spd size byte MEM_MB=64");
    rd('h180, 32'h0, "R9 upper window zero");
    rd('h1FC, 32'h0, "R9 upper window end zero");

    // local interrupts (R10, R11, R12)
    wr('h50, 32'hFFFF_FFFE);
    rd('h44, 0, "R11 soft set ignores upper bits");
    wr('h50, 32'h0000_0001);
    chk("R12 irq masked", 32'(irq), 0);
    rd('h44, 1, "R10 raw");
    rd('h40, 0, "R10 irq status masked");
    rd('h50, 1, "R11 soft readback");
    wr('h48, 32'h0000_0001);
    chk("R12 irq on", 32'(irq), 1);
    chk("R12 fiq off", 32'(fiq), 0);
    rd('h40, 1, "R10 irq status");
    rd('h48, 1, "R10 irq enable");
    wr('h68, 32'h0000_0003);
    chk("R12 fiq on", 32'(fiq), 1);
    rd('h68, 3, "R10 fiq enable");
    rd('h64, 1, "R10 fiq raw");
    rd('h60, 1, "R10 fiq status");
    wr('h54, 32'hFFFF_FFFE);
    chk("R11 soft clear ignores upper bits", 32'(irq), 1);
    rd('h44, 1, "R11 raw kept");
    wr('h6C, 32'h0000_0002);
    rd('h68, 1, "R10 fiq enable clear");
    wr('h54, 32'h0000_0001);
    chk("R11 irq after clear", 32'(irq), 0);
    chk("R11 fiq after clear", 32'(fiq), 0);
    rd('h50, 0, "R11 soft cleared");
    wr('h50, 32'h0000_0001);
    wr('h4C, 32'h0000_0001);
    chk("R12 irq enable clear", 32'(irq), 0);
    chk("R12 fiq still on", 32'(fiq), 1);
    rd('h48, 0, "R10 irq enable cleared");

    repeat (3) idle();
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R13: actual %0d pending reads expected 0", exp_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    done = 1'b1;
    $finish;
  end
endmodule